// File: doc/BRIEF.md
# Radix-4 Booth Recoded Multiplier

This block multiplies two W-bit operands and delivers the full 2W-bit product one clock after the operands are presented. A mode input picks between unsigned and two's complement signed interpretation of both operands. Both operands are sampled together with the mode at the same edge.

The multiplier operand is recoded in overlapping three-bit windows. A zero is placed below its least significant bit, and each window shares its lowest bit with the top bit of the window below it. Every window goes to its own small encoder, and all encoders work in parallel with no carry between them. Each encoder emits three select lines: pick the multiplicand once, pick it doubled, and invert. A row generator turns each set of select lines into one partial product, using only pairs of neighbouring multiplicand bits. Negation is done as bitwise inversion, and the missing +1 is injected at the row's weight during the final sum. The rows are sign extended, shifted by two bit positions per window and added. In unsigned mode both operands are zero extended, so the top window never recodes to a negative digit. In signed mode they are sign extended.

Top module: `booth_mul`

## Requirements
- R1: When `rst` is high at a rising edge, `prod` becomes 0 at that edge.
- R2: `prod` after a rising edge is the product of `mcand`, `mplier` and `mode_signed` sampled at that same edge, so the latency is one cycle.
- R3: With `mode_signed` = 0, both operands are unsigned and `prod` is their exact 2W-bit unsigned product.
- R4: With `mode_signed` = 1, both operands are two's complement and `prod` is their exact 2W-bit two's complement product.
- R5: Every window value recodes by this table, and every multiplier value gives a correct product: 000 and 111 give 0, 001 and 010 give +X, 011 gives +2X, 100 gives -2X, 101 and 110 give -X. The window bits are ordered {high, middle, low}.
- R6: In unsigned mode, a multiplier with its top bit set (for example all ones) gives a non-negative product equal to the unsigned result.
- R7: In signed mode, the most negative multiplicand is correct under ±X and ±2X selection. For W = 8, -128 × -128 = 16384 and -128 × 127 = -16256.
- R8: A zero multiplicand or a zero multiplier gives a zero product in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier, the Booth recoded operand |
| prod | output | 2W | Registered product |

## Verification
The bench sweeps every multiplier value against a fixed multiplicand in both modes. This puts each window code at each row position, so an encoder table error shows up as a product off by a multiple of the multiplicand at that row's weight. Directed cases go after the most negative multiplicand and unsigned multipliers with the top bit set. A missing +1 for a negated row, a sign extension applied in unsigned mode, or a missing extra top window would each give products that are wrong by a power of two or have the wrong sign. Zero operands catch the case where inversion of a zero row is not cancelled by its +1.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef struct packed {
    logic one;  // select multiplicand once
    logic two;  // select multiplicand doubled
    logic neg;  // invert selected value
  } booth_sel_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0] grp,
  output booth_sel_t sel
);
  always_comb begin
    sel.one = grp[1] ^ grp[0];
    sel.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    sel.neg = grp[2] & ~(grp[1] & grp[0]);
  end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_pkg::*;
#(
  parameter int PPW = 10
) (
  input  logic [PPW-1:0] xe,
  input  booth_sel_t     sel,
  output logic [PPW-1:0] pp
);
  logic [PPW:0] xs;
  assign xs = {xe, 1'b0};

  for (genvar i = 0; i < PPW; i++) begin : g_bit
    assign pp[i] = ((sel.one & xs[i+1]) | (sel.two & xs[i])) ^ sel.neg;
  end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_signed,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int PPW = W + 2;
  localparam int YW  = (W % 2 == 0) ? W + 2 : W + 1;
  localparam int G   = YW / 2;
  localparam int SW  = 2 * W;

  logic              xext, yext;
  logic [PPW-1:0]    xe;
  logic [YW:0]       yp;
  booth_sel_t        sel [G];
  logic [G-1:0][PPW-1:0] pp;
  logic [SW-1:0]     sum;

  assign xext = mode_signed & mcand[W-1];
  assign yext = mode_signed & mplier[W-1];
  assign xe   = {{2{xext}}, mcand};
  assign yp   = {{(YW-W){yext}}, mplier, 1'b0};

  for (genvar j = 0; j < G; j++) begin : g_row
    booth_enc u_enc (
      .grp (yp[2*j+2 -: 3]),
      .sel (sel[j])
    );
    booth_ppgen #(.PPW(PPW)) u_pp (
      .xe  (xe),
      .sel (sel[j]),
      .pp  (pp[j])
    );
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < G; j++) begin
      sum = sum + (({{(SW-PPW){pp[j][PPW-1]}}, pp[j]}) << (2*j))
                + (SW'(sel[j].neg) << (2*j));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= sum;
  end
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           mode_signed,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic [2*W-1:0] prod
);
  logic armed;
  logic [2*W-1:0] ua, ub, sa, sb;

  always_ff @(posedge clk) armed <= !rst;

  assign ua = {{W{1'b0}}, mcand};
  assign ub = {{W{1'b0}}, mplier};
  assign sa = {{W{mcand[W-1]}}, mcand};
  assign sb = {{W{mplier[W-1]}}, mplier};

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> prod == '0);

  a_r3_unsigned_prod: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(mode_signed)) |-> prod == ($past(ua) * $past(ub)));

  a_r4_signed_prod: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mode_signed)) |-> prod == ($past(sa) * $past(sb)));

  a_r8_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(mcand) == '0 || $past(mplier) == '0)) |-> prod == '0);
endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (.*);

// File: tb/booth_mul_bench.sv
module booth_mul_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic           clk = 0;
  logic           rst;
  logic           mode_signed;
  logic [W-1:0]   mcand, mplier;
  logic [2*W-1:0] prod;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul #(.W(W)) u_booth_mul (
    .clk(clk), .rst(rst), .mode_signed(mode_signed),
    .mcand(mcand), .mplier(mplier), .prod(prod)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic s);
    logic [2*W-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] exp);
    total++;
    if (prod !== exp) begin
      bad++;
      $display("FAIL %s: a=%h b=%h mode=%0b got=%h exp=%h",
               req, mcand, mplier, mode_signed, prod, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input string req);
    @(negedge clk);
    mcand = a; mplier = b; mode_signed = s;
    @(negedge clk);
    check(req, ref_mul(a, b, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; mode_signed = 1; mcand = 8'h7F; mplier = 8'h7F;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst = 0;
    // R2: one-cycle latency, back-to-back operands
    apply(8'd3, 8'd5, 1'b0, "R2 latency");
    apply(8'd200, 8'd7, 1'b0, "R2 back-to-back");
    // R5: every multiplier value, both modes
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 256; b++)
        apply(8'h5B, 8'(b), 1'(m), "R5 recode sweep");
    // R6: unsigned multiplier with top bit set
    apply(8'hFF, 8'hFF, 1'b0, "R6 unsigned all ones");
    apply(8'h01, 8'h80, 1'b0, "R6 unsigned top bit");
    // R7: most negative multiplicand
    apply(8'h80, 8'h80, 1'b1, "R7 min*min");
    check("R7 min*min value", 16'd16384);
    apply(8'h80, 8'h7F, 1'b1, "R7 min*max");
    check("R7 min*max value", 16'hC080);
    apply(8'h80, 8'h01, 1'b1, "R7 min*1");
    // R8: zero operands
    apply(8'h00, 8'hAB, 1'b1, "R8 zero mcand");
    apply(8'hC3, 8'h00, 1'b0, "R8 zero mplier");
    apply(8'h00, 8'h00, 1'b1, "R8 both zero");
    // R3 / R4: constrained random
    for (int k = 0; k < 400; k++)
      apply(8'($urandom), 8'($urandom), 1'b0, "R3 unsigned random");
    for (int k = 0; k < 400; k++)
      apply(8'($urandom), 8'($urandom), 1'b1, "R4 signed random");
    // R1: reset mid-run clears product
    @(negedge clk); rst = 1; mcand = 8'h33; mplier = 8'h44;
    @(negedge clk);
    check("R1 mid-run reset", '0);
    rst = 0;
    apply(8'h33, 8'h44, 1'b1, "R4 after reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule